// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds two 16-bit external data pointers and a one-bit selector that picks which of them is active. All three registers are mapped as bytes into the special function register (SFR) space. The core reaches them through a small SFR bus with an address, write data, a write enable and a read enable. Read data is returned combinationally in the same cycle.

The core also drives operation strobes: load a 16-bit immediate, increment by one, and increment the selector. Each strobe acts only on the pointer chosen by the selector. The active pointer appears on a 16-bit output, which serves as the address for external data moves and table lookups. A block copy can hold its source address in one pointer and its destination in the other, and one selector increment swaps between them.

Top module: `dual_ptr_unit`

## Requirements
- R1: After reset, both pointers are 0000h and the selector is 0.
- R2: SFR address 82h holds the low byte and 83h the high byte of pointer 0. Address 84h holds the low byte and 85h the high byte of pointer 1. A write to any of these addresses is read back at the same address. With read enable low, or at any unmapped address, the read data is 00h.
- R3: Address 86h holds the selector in bit 0. Bits 7 to 1 always read as 0, and write data in those bits has no effect.
- R4: The pointer output equals pointer 0 when the selector is 0 and pointer 1 when the selector is 1.
- R5: A load strobe writes the 16-bit immediate into the selected pointer. The other pointer keeps its value.
- R6: An increment strobe adds one to the selected pointer only, and FFFFh wraps to 0000h.
- R7: The selector-increment strobe inverts the selector. If an SFR write to 86h happens in the same cycle, the write decides the new value.
- R8: An SFR write to any pointer byte takes effect whatever the selector value is.
- R9: When an SFR write to a pointer byte coincides with a load or increment of that pointer, the written byte takes the SFR data. The other byte takes the result of the operation.
- R10: When load and increment are strobed together, the load takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | SFR byte address |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_we_i | input | 1 | SFR write enable |
| sfr_re_i | input | 1 | SFR read enable |
| sfr_rdata_o | output | 8 | SFR read data, combinational |
| op_load_i | input | 1 | Load immediate into selected pointer |
| op_load_data_i | input | 16 | Immediate value for load |
| op_inc_i | input | 1 | Increment selected pointer |
| op_sel_inc_i | input | 1 | Increment (toggle) the selector |
| dptr_o | output | 16 | Active pointer |

## Verification
The assertions check several rules on every cycle:
- a pointer that is neither selected nor written holds its value;
- an increment from FFFFh lands on 0000h;
- a byte write overrides a concurrent pointer operation on that byte;
- a load overrides an increment;
- the selector inverts on its strobe unless a write to 86h takes over;
- the upper bits of 86h read as zero.

Some behaviour shows only in the bench scenarios. These are that the output follows the selector across switches, that pointer bytes written while the other pointer is active still land, that the other byte keeps the operation result in a collision, and that an SFR read returns every mapped byte correctly.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned SFR_AW    = 8;
  localparam int unsigned SFR_DW    = 8;
  localparam int unsigned DPTR_BASE = 'h82;  // lo/hi pairs ascend from here
  localparam int unsigned SEL_ADDR  = 'h86;
  localparam int unsigned NUM_PTR   = 2;     // one select bit
endpackage

// File: rtl/dptr_reg.sv
module dptr_reg #(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned LO_ADDR = 'h82,
  parameter int unsigned HI_ADDR = 'h83,
  localparam int unsigned PW     = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          ld_i,
  input  logic [PW-1:0] ld_data_i,
  input  logic          inc_i,
  input  logic [AW-1:0] sfr_addr_i,
  input  logic [DW-1:0] sfr_wdata_i,
  input  logic          sfr_we_i,
  output logic [PW-1:0] q_o
);
  logic          we_lo, we_hi;
  logic [PW-1:0] op_val, nxt;

  assign we_lo = sfr_we_i && (sfr_addr_i == AW'(LO_ADDR));
  assign we_hi = sfr_we_i && (sfr_addr_i == AW'(HI_ADDR));

  // load beats increment; only the selected pointer moves
  always_comb begin
    op_val = q_o;
    if (active_i) begin
      if (ld_i)       op_val = ld_data_i;
      else if (inc_i) op_val = q_o + PW'(1);
    end
  end

  // SFR byte write beats operation on that byte
  always_comb begin
    nxt = op_val;
    if (we_lo) nxt[DW-1:0]  = sfr_wdata_i;
    if (we_hi) nxt[PW-1:DW] = sfr_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && inc_i && !ld_i && !we_lo && !we_hi && (q_o == '1) |=> q_o == '0);

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i && !we_lo && !we_hi |=> $stable(q_o));

  p_lo_wr_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo |=> q_o[DW-1:0] == $past(sfr_wdata_i));

  p_hi_wr_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_hi |=> q_o[PW-1:DW] == $past(sfr_wdata_i));

  p_load_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && ld_i && !we_lo && !we_hi |=> q_o == $past(ld_data_i));
endmodule

// File: rtl/dptr_sel_reg.sv
module dptr_sel_reg #(
  parameter int unsigned AW   = 8,
  parameter int unsigned ADDR = 'h86
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] sfr_addr_i,
  input  logic          sfr_wbit_i,
  input  logic          sfr_we_i,
  input  logic          tgl_i,
  output logic          sel_o
);
  logic we_hit;
  assign we_hit = sfr_we_i && (sfr_addr_i == AW'(ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_o <= 1'b0;
    else if (we_hit) sel_o <= sfr_wbit_i;
    else if (tgl_i)  sel_o <= ~sel_o;
  end

  p_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgl_i && !we_hit |=> sel_o != $past(sel_o));

  p_wr_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_hit |=> sel_o == $past(sfr_wbit_i));
endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
  import dptr_pkg::*;
#(
  parameter int unsigned AW   = SFR_AW,
  parameter int unsigned DW   = SFR_DW,
  parameter int unsigned BASE = DPTR_BASE,
  parameter int unsigned SADR = SEL_ADDR,
  localparam int unsigned PW  = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] sfr_addr_i,
  input  logic [DW-1:0] sfr_wdata_i,
  input  logic          sfr_we_i,
  input  logic          sfr_re_i,
  output logic [DW-1:0] sfr_rdata_o,
  input  logic          op_load_i,
  input  logic [PW-1:0] op_load_data_i,
  input  logic          op_inc_i,
  input  logic          op_sel_inc_i,
  output logic [PW-1:0] dptr_o
);
  logic          sel;
  logic [PW-1:0] ptr_q [NUM_PTR];

  dptr_sel_reg #(.AW(AW), .ADDR(SADR)) i_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sfr_addr_i (sfr_addr_i),
    .sfr_wbit_i (sfr_wdata_i[0]),
    .sfr_we_i   (sfr_we_i),
    .tgl_i      (op_sel_inc_i),
    .sel_o      (sel)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    dptr_reg #(
      .AW(AW), .DW(DW),
      .LO_ADDR(BASE + 2*g), .HI_ADDR(BASE + 2*g + 1)
    ) i_ptr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .active_i    (sel == 1'(g)),
      .ld_i        (op_load_i),
      .ld_data_i   (op_load_data_i),
      .inc_i       (op_inc_i),
      .sfr_addr_i  (sfr_addr_i),
      .sfr_wdata_i (sfr_wdata_i),
      .sfr_we_i    (sfr_we_i),
      .q_o         (ptr_q[g])
    );
  end

  assign dptr_o = ptr_q[sel];

  always_comb begin
    sfr_rdata_o = '0;
    if (sfr_re_i) begin
      for (int i = 0; i < NUM_PTR; i++) begin
        if (sfr_addr_i == AW'(BASE + 2*i))     sfr_rdata_o = ptr_q[i][DW-1:0];
        if (sfr_addr_i == AW'(BASE + 2*i + 1)) sfr_rdata_o = ptr_q[i][PW-1:DW];
      end
      if (sfr_addr_i == AW'(SADR)) sfr_rdata_o = DW'(sel);
    end
  end

  p_sel_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_re_i && (sfr_addr_i == AW'(SADR)) |-> sfr_rdata_o[DW-1:1] == '0);

  p_idle_rd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sfr_re_i |-> sfr_rdata_o == '0);
endmodule

// File: tb/test_dual_ptr_unit.sv
module test_dual_ptr_unit;
  localparam time CLK_P = 10ns;

  logic        clk = 0, rst_ni = 0;
  logic [7:0]  sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic        sfr_we = 0, sfr_re = 0;
  logic        op_load = 0, op_inc = 0, op_sel_inc = 0;
  logic [15:0] op_load_data = 0, dptr;

  always #(CLK_P/2) clk = ~clk;

  dual_ptr_unit i_dual_ptr_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .sfr_addr_i(sfr_addr), .sfr_wdata_i(sfr_wdata), .sfr_we_i(sfr_we), .sfr_re_i(sfr_re),
    .sfr_rdata_o(sfr_rdata),
    .op_load_i(op_load), .op_load_data_i(op_load_data), .op_inc_i(op_inc),
    .op_sel_inc_i(op_sel_inc), .dptr_o(dptr)
  );

  typedef struct { string req; bit is_ptr; logic [15:0] exp; } item_t;
  item_t sb_q[$];
  event  smp_ev;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  logic [15:0] m_p [2];
  logic        m_sel;

  // monitor
  initial forever begin
    @(smp_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      act = it.is_ptr ? dptr : {8'h00, sfr_rdata};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h82: return m_p[0][7:0];
      8'h83: return m_p[0][15:8];
      8'h84: return m_p[1][7:0];
      8'h85: return m_p[1][15:8];
      8'h86: return {7'b0, m_sel};
      default: return 8'h00;
    endcase
  endfunction

  task automatic push(input string req, input bit is_ptr, input logic [15:0] e);
    item_t it;
    it.req = req; it.is_ptr = is_ptr; it.exp = e;
    sb_q.push_back(it);
    #1 -> smp_ev;
    #1;
  endtask

  // full state check; called right after a negedge
  task automatic chk(input string req);
    push({req, "/R4 dptr"}, 1, m_p[m_sel]);
    for (int a = 'h81; a <= 'h87; a++) begin
      sfr_addr = 8'(a); sfr_re = 1;
      push({req, "/R2 read"}, 0, {8'h00, exp_rd(8'(a))});
    end
    sfr_re = 0; sfr_addr = 8'h82;
    push("R2 re low", 0, 16'h0000);
  endtask

  // one clock of stimulus with model update
  task automatic step(input logic ld, input logic [15:0] ldv, input logic inc,
                      input logic tgl, input logic we, input logic [7:0] a,
                      input logic [7:0] wd);
    logic [15:0] n;
    op_load = ld; op_load_data = ldv; op_inc = inc; op_sel_inc = tgl;
    sfr_we = we; sfr_addr = a; sfr_wdata = wd; sfr_re = 0;
    n = m_p[m_sel];
    if (ld) n = ldv; else if (inc) n = n + 16'd1;
    m_p[m_sel] = n;
    if (we) case (a)
      8'h82: m_p[0][7:0]  = wd;
      8'h83: m_p[0][15:8] = wd;
      8'h84: m_p[1][7:0]  = wd;
      8'h85: m_p[1][15:8] = wd;
      default: ;
    endcase
    if (we && a == 8'h86) m_sel = wd[0];
    else if (tgl)         m_sel = ~m_sel;
    @(posedge clk);
    @(negedge clk);
    op_load = 0; op_inc = 0; op_sel_inc = 0; sfr_we = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(0, 16'h0, 0, 0, 1, a, d);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    m_p[0] = 0; m_p[1] = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk("R1 reset");

    wr(8'h82, 8'h11); wr(8'h83, 8'h22); wr(8'h84, 8'h33); wr(8'h85, 8'h44);
    chk("R2 R8 byte writes sel0");

    wr(8'h86, 8'hFF);
    chk("R3 upper bits ignored, sel=1");
    wr(8'h86, 8'hFE);
    chk("R3 write FE gives sel=0");

    step(1, 16'h1234, 0, 0, 0, 8'h00, 8'h00);
    chk("R5 load ptr0 only");
    step(0, 16'h0, 0, 1, 0, 8'h00, 8'h00);
    chk("R7 R4 toggle to ptr1");
    step(1, 16'hFFFF, 0, 0, 0, 8'h00, 8'h00);
    chk("R5 load ptr1 only");
    step(0, 16'h0, 1, 0, 0, 8'h00, 8'h00);
    chk("R6 wrap FFFF to 0000");
    step(0, 16'h0, 1, 0, 0, 8'h00, 8'h00);
    chk("R6 inc ptr1 only");

    wr(8'h83, 8'h9A);
    chk("R8 ptr0 write while sel1");

    step(1, 16'h00FF, 0, 0, 1, 8'h84, 8'h55);
    chk("R9 write lo beats load");
    step(0, 16'h0, 1, 0, 1, 8'h85, 8'h77);
    chk("R9 write hi beats inc");

    step(1, 16'h4000, 1, 0, 0, 8'h00, 8'h00);
    chk("R10 load beats inc");

    step(0, 16'h0, 0, 1, 1, 8'h86, 8'h01);
    chk("R7 write beats toggle");
    step(0, 16'h0, 0, 1, 0, 8'h00, 8'h00);
    chk("R7 toggle back to ptr0");
    step(0, 16'h0, 1, 0, 0, 8'h00, 8'h00);
    chk("R6 R4 inc ptr0");

    done = 1;
    #1;
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule